// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Posted Register Writes

This block keeps wall-clock time as a 32-bit count of seconds plus a fractional sub-second count driven by a slow reference clock (32 kHz class). The slow clock is brought into the system clock domain by a small synchronizer. Each rising edge of the synchronized slow clock is one tick. Software reaches the block through seven 32-bit word registers on a simple single-cycle bus:

| Word | Register |
|---|---|
| 0 | seconds |
| 1 | fraction |
| 2 | alarm high |
| 3 | alarm low |
| 4 | control |
| 5 | status |
| 6 | interrupt enable |

Writes to the time, alarm and control registers are posted. The block accepts the value at once, but it only applies it after a fixed number of ticks. During that time a busy flag is raised. When the value lands, a completion flag is set, so software can poll for the end of the write. A second posted write that arrives during this window is dropped and raises an error flag instead. Status and interrupt-enable writes take effect on the next clock edge.

The time counter runs only when its enable bit is set. It also stays frozen after power-up until the seconds register has been written once. To set the time, software clears the fraction and then writes the seconds. An alarm comparator flags the moment the time equals the alarm value. A validity flag and a security flag mark time that cannot be trusted. A single interrupt line ORs together the enabled status flags.

Top module: `rtc_secs`

## Requirements
- R1: After reset these registers read zero: seconds, fraction, alarm low, control and interrupt enable. Alarm high reads 0xFFFFFFFF. Status reads 0x00000202, which is the non-valid flag (bit 1) plus the write-next flag (bit 9). `irq_o` is low.
- R2: Word addresses are: 0 seconds, 1 fraction, 2 alarm high, 3 alarm low, 4 control, 5 status, 6 interrupt enable. A completed posted write to a register reads back as written, with these exceptions:
  - Control keeps only bit 3.
  - Interrupt enable keeps only bits 9, 8, 7 and 4.
  - Fraction keeps only its low FRAC_BITS bits.
  - All other bits read zero.
- R3: A write to words 0 to 4 raises write-busy (status bit 10) and drops write-next (bit 9) on the next clock. The old value stays visible while busy is high. On the COMMIT_TICKS-th tick after the write (4 by default), the block applies the value, clears busy and sets write-complete (bit 8).
- R4: A posted write issued while busy is high is discarded and sets write-error (status bit 7). The pending write still completes with its own value.
- R5: The counter moves only on a tick. Control bit 3 must be set, and seconds must have been written at least once since reset. Otherwise seconds and fraction hold.
- R6: The fraction counts 2^FRAC_BITS ticks per second. When it passes its maximum it returns to zero and seconds increments in the same clock. Seconds wraps from 0xFFFFFFFF to 0.
- R7: The alarm flag (status bit 4) is set once, on the clock after seconds equals alarm high and the fraction equals the low FRAC_BITS bits of alarm low. An alarm high of 0xFFFFFFFF disables the alarm.
- R8: Writing 1 to status bit 8, 7 or 4 clears that flag. Writing 0 leaves a flag unchanged. Status writes are never posted and never raise write-error.
- R9: A pulse on `violation_i` sets both the security-violation flag (bit 0) and the non-valid flag (bit 1). Both clear only on one status write that has bits 1 and 0 both set. A write with only one of the two bits set leaves both flags as they were.
- R10: `irq_o` is high exactly when one of status bits 9, 8, 7 or 4 is set together with the interrupt-enable bit at the same position.
- R11: A write to the fraction alone loads that fraction, including zero, and leaves seconds unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_clk_i | input | 1 | Slow reference clock, synchronized inside the block |
| violation_i | input | 1 | Security violation pulse, synchronous to clk |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high together with bus_sel_i |
| bus_addr_i | input | 3 | Word address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed register (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions take several things for granted about the inputs:
- A bus write lasts one clock.
- `violation_i` is already synchronous to the system clock.
- The slow clock toggles much more slowly than the system clock, so the synchronizer produces isolated one-cycle ticks.

The bench drives the slow clock at a quarter of the system clock rate, holds every bus strobe for exactly one cycle, and pulses `violation_i` from the same negative edge as the other inputs. Random register values come from a seeded generator. The bench only issues a second posted write during a busy window when it is deliberately testing the discard path.

// File: rtl/rtc_secs_pkg.sv
// Shared constants for the seconds counter RTC: register word indices,
// status bit positions and the posted-write record.
package rtc_secs_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_SECS   = 3'd0;
    localparam logic [ADDR_W-1:0] A_FRAC   = 3'd1;
    localparam logic [ADDR_W-1:0] A_ALM_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_ALM_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;
    localparam logic [ADDR_W-1:0] A_IEN    = 3'd6;

    localparam int CTRL_RUN = 3;

    localparam int ST_BUSY  = 10;
    localparam int ST_NEXT  = 9;
    localparam int ST_DONE  = 8;
    localparam int ST_WERR  = 7;
    localparam int ST_ALARM = 4;
    localparam int ST_NVAL  = 1;
    localparam int ST_SVIO  = 0;

    localparam logic [REG_W-1:0] IRQ_MASK =
        (REG_W'(1) << ST_NEXT) | (REG_W'(1) << ST_DONE) |
        (REG_W'(1) << ST_WERR) | (REG_W'(1) << ST_ALARM);

    // One posted write waiting for its commit tick.
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  data;
    } post_t;

endpackage

// File: rtl/rtc_tick_sync.sv
// Brings the slow reference clock into the clk domain and emits a one-cycle
// tick on each of its rising edges.
// Assumes the slow clock is at least a few times slower than clk.
module rtc_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_clk_i,
    output logic tick_o
);

    logic [STAGES:0] shift_q;

    // Synchronizer chain with one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[STAGES-1:0], slow_clk_i};
    end

    // Rising edge of the synchronized slow clock.
    assign tick_o = shift_q[STAGES-1] & ~shift_q[STAGES];

endmodule

// File: rtl/rtc_post_ctl.sv
// Posted write engine: it holds one accepted write, counts COMMIT_TICKS
// ticks, and then raises commit_o for one clock. A write request that
// arrives while a write is pending is rejected.
// Assumes req_i is high for one clock per bus write.
module rtc_post_ctl
    import rtc_secs_pkg::*;
#(
    parameter int COMMIT_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [REG_W-1:0]  req_data_i,
    output logic              busy_o,
    output logic              commit_o,
    output logic              reject_o,
    output post_t             pend_o
);

    localparam int CNT_W = $clog2(COMMIT_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(COMMIT_TICKS - 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    post_t            pend_q;

    assign commit_o = busy_q & tick_i & (cnt_q == LAST);
    assign reject_o = req_i & busy_q;
    assign busy_o   = busy_q;
    assign pend_o   = pend_q;

    // Accept a write, count ticks while busy, and release on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            pend_q <= '0;
        end else if (commit_o) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (req_i && !busy_q) begin
            busy_q      <= 1'b1;
            cnt_q       <= '0;
            pend_q.addr <= req_addr_i;
            pend_q.data <= req_data_i;
        end else if (busy_q && tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rtc_timebase.sv
// Seconds and fraction counters with the alarm comparator. A load of either
// counter takes priority over counting. The alarm hit pulses on the first
// clock of a match.
module rtc_timebase
    import rtc_secs_pkg::*;
#(
    parameter int FRAC_BITS = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 run_i,
    input  logic                 ld_sec_i,
    input  logic                 ld_frac_i,
    input  logic [REG_W-1:0]     ld_data_i,
    input  logic [REG_W-1:0]     alm_hi_i,
    input  logic [FRAC_BITS-1:0] alm_lo_i,
    output logic [REG_W-1:0]     sec_o,
    output logic [FRAC_BITS-1:0] frac_o,
    output logic                 hit_o
);

    logic [REG_W-1:0]     sec_q;
    logic [FRAC_BITS-1:0] frac_q;
    logic                 match_q;
    logic                 step;
    logic                 wrap;
    logic                 match;

    assign step  = run_i & tick_i;
    assign wrap  = step & ~ld_frac_i & (frac_q == {FRAC_BITS{1'b1}});
    assign match = (alm_hi_i != {REG_W{1'b1}}) &&
                   (sec_q == alm_hi_i) && (frac_q == alm_lo_i);

    // Fraction: load, or advance by one per running tick.
    always_ff @(posedge clk) begin
        if (!rst_n)         frac_q <= '0;
        else if (ld_frac_i) frac_q <= ld_data_i[FRAC_BITS-1:0];
        else if (step)      frac_q <= frac_q + 1'b1;
    end

    // Seconds: load, or advance on fraction rollover.
    always_ff @(posedge clk) begin
        if (!rst_n)        sec_q <= '0;
        else if (ld_sec_i) sec_q <= ld_data_i;
        else if (wrap)     sec_q <= sec_q + 1'b1;
    end

    // Match history so that a match raises the hit only once.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match;
    end

    assign hit_o  = match & ~match_q;
    assign sec_o  = sec_q;
    assign frac_o = frac_q;

endmodule

// File: rtl/rtc_secs.sv
// Top of the seconds counter RTC. It decodes the register bus, routes
// posted writes through the commit engine, and keeps the control,
// alarm, flag and interrupt-enable state.
// Assumes one-clock bus strobes and a violation_i that is synchronous to clk.
module rtc_secs
    import rtc_secs_pkg::*;
#(
    parameter int FRAC_BITS    = 15,
    parameter int COMMIT_TICKS = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk_i,
    input  logic              violation_i,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [REG_W-1:0]  bus_wdata_i,
    output logic [REG_W-1:0]  bus_rdata_o,
    output logic              irq_o
);

    logic                 tick;
    logic                 wr;
    logic                 post_req;
    logic                 stat_wr;
    logic                 ien_wr;
    logic                 post_busy;
    logic                 post_commit;
    logic                 post_reject;
    post_t                pend;
    logic                 ld_sec;
    logic                 ld_frac;
    logic                 ld_hi;
    logic                 ld_lo;
    logic                 ld_ctrl;
    logic                 clr_pair;
    logic                 run_en;
    logic                 alarm_hit;
    logic [REG_W-1:0]     sec;
    logic [FRAC_BITS-1:0] frac;
    logic [REG_W-1:0]     alm_hi_q;
    logic [REG_W-1:0]     alm_lo_q;
    logic                 ctrl_run_q;
    logic                 seeded_q;
    logic                 st_done;
    logic                 st_werr;
    logic                 st_alarm;
    logic                 st_nval;
    logic                 st_svio;
    logic [REG_W-1:0]     ie_q;
    logic [REG_W-1:0]     status_w;

    assign wr       = bus_sel_i & bus_we_i;
    assign post_req = wr & (bus_addr_i <= A_CTRL);
    assign stat_wr  = wr & (bus_addr_i == A_STAT);
    assign ien_wr   = wr & (bus_addr_i == A_IEN);
    assign clr_pair = stat_wr & bus_wdata_i[ST_NVAL] & bus_wdata_i[ST_SVIO];

    assign ld_sec  = post_commit & (pend.addr == A_SECS);
    assign ld_frac = post_commit & (pend.addr == A_FRAC);
    assign ld_hi   = post_commit & (pend.addr == A_ALM_HI);
    assign ld_lo   = post_commit & (pend.addr == A_ALM_LO);
    assign ld_ctrl = post_commit & (pend.addr == A_CTRL);
    assign run_en  = ctrl_run_q & seeded_q;

    rtc_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_clk_i (slow_clk_i),
        .tick_o     (tick)
    );

    rtc_post_ctl #(.COMMIT_TICKS(COMMIT_TICKS)) u_post (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .req_i      (post_req),
        .req_addr_i (bus_addr_i),
        .req_data_i (bus_wdata_i),
        .busy_o     (post_busy),
        .commit_o   (post_commit),
        .reject_o   (post_reject),
        .pend_o     (pend)
    );

    rtc_timebase #(.FRAC_BITS(FRAC_BITS)) u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .run_i     (run_en),
        .ld_sec_i  (ld_sec),
        .ld_frac_i (ld_frac),
        .ld_data_i (pend.data),
        .alm_hi_i  (alm_hi_q),
        .alm_lo_i  (alm_lo_q[FRAC_BITS-1:0]),
        .sec_o     (sec),
        .frac_o    (frac),
        .hit_o     (alarm_hit)
    );

    // Alarm halves and the run bit, applied on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_hi_q   <= '1;
            alm_lo_q   <= '0;
            ctrl_run_q <= 1'b0;
        end else begin
            if (ld_hi)   alm_hi_q   <= pend.data;
            if (ld_lo)   alm_lo_q   <= pend.data;
            if (ld_ctrl) ctrl_run_q <= pend.data[CTRL_RUN];
        end
    end

    // The counter stays frozen until the seconds register has been written once.
    always_ff @(posedge clk) begin
        if (!rst_n)      seeded_q <= 1'b0;
        else if (ld_sec) seeded_q <= 1'b1;
    end

    // Sticky status flags: the setting event wins over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_done  <= 1'b0;
            st_werr  <= 1'b0;
            st_alarm <= 1'b0;
            st_nval  <= 1'b1;
            st_svio  <= 1'b0;
        end else begin
            st_done  <= post_commit | (st_done  & ~(stat_wr & bus_wdata_i[ST_DONE]));
            st_werr  <= post_reject | (st_werr  & ~(stat_wr & bus_wdata_i[ST_WERR]));
            st_alarm <= alarm_hit   | (st_alarm & ~(stat_wr & bus_wdata_i[ST_ALARM]));
            st_nval  <= violation_i | (st_nval  & ~clr_pair);
            st_svio  <= violation_i | (st_svio  & ~clr_pair);
        end
    end

    // Interrupt enables are written immediately, masked to implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      ie_q <= '0;
        else if (ien_wr) ie_q <= bus_wdata_i & IRQ_MASK;
    end

    // Assemble the status word from live and sticky flags.
    always_comb begin
        status_w           = '0;
        status_w[ST_BUSY]  = post_busy;
        status_w[ST_NEXT]  = ~post_busy;
        status_w[ST_DONE]  = st_done;
        status_w[ST_WERR]  = st_werr;
        status_w[ST_ALARM] = st_alarm;
        status_w[ST_NVAL]  = st_nval;
        status_w[ST_SVIO]  = st_svio;
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_SECS:   bus_rdata_o = sec;
            A_FRAC:   bus_rdata_o = REG_W'(frac);
            A_ALM_HI: bus_rdata_o = alm_hi_q;
            A_ALM_LO: bus_rdata_o = alm_lo_q;
            A_CTRL:   bus_rdata_o[CTRL_RUN] = ctrl_run_q;
            A_STAT:   bus_rdata_o = status_w;
            A_IEN:    bus_rdata_o = ie_q;
            default:  bus_rdata_o = '0;
        endcase
    end

    assign irq_o = |(status_w & ie_q);

endmodule

// File: rtl/rtc_secs_chk.sv
// Property checker for rtc_secs, attached by the bind at the end of this file.
// Assumes one-clock bus strobes and isolated one-cycle ticks.
module rtc_secs_chk #(
    parameter int COMMIT_TICKS = 4,
    parameter int FRAC_BITS    = 15
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick,
    input logic                 busy,
    input logic                 commit,
    input logic                 post_req,
    input logic                 clr_pair,
    input logic                 run_en,
    input logic [FRAC_BITS-1:0] frac,
    input logic [31:0]          status,
    input logic [31:0]          ie,
    input logic [31:0]          alm_hi,
    input logic                 irq
);

    int unsigned busy_ticks;

    // Count ticks seen during a busy window; the commit tick is not counted.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_ticks <= 0;
        else if (tick)       busy_ticks <= busy_ticks + 1;
    end

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_ticks <= COMMIT_TICKS - 1));                         // R3

    AST_COMPLETE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> status[8]);                                         // R3

    AST_REJECT_FLAGS_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (post_req && busy) |=> status[7]);                                  // R4

    AST_FROZEN_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !commit) |=> $stable(frac));                            // R5

    AST_ALARM_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_hi == 32'hFFFF_FFFF && !status[4] && !commit) |=> !status[4]); // R7

    AST_NVAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !clr_pair) |=> status[1]);                            // R9

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == 32'd0) |-> !irq);                                            // R10

endmodule

bind rtc_secs rtc_secs_chk #(.COMMIT_TICKS(COMMIT_TICKS), .FRAC_BITS(FRAC_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .busy     (post_busy),
    .commit   (post_commit),
    .post_req (post_req),
    .clr_pair (clr_pair),
    .run_en   (run_en),
    .frac     (frac),
    .status   (status_w),
    .ie       (ie_q),
    .alm_hi   (alm_hi_q),
    .irq      (irq_o)
);

// File: tb/rtc_secs_tb.sv
// Self-checking bench for rtc_secs: seeded random register traffic plus
// directed timing, rollover, alarm and flag cases.
module rtc_secs_tb;

    localparam int CLK_PERIOD = 10;
    localparam int FRAC_BITS  = 4;
    localparam int COMMIT     = 4;
    localparam int FRAC_STEPS = 1 << FRAC_BITS;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_clk = 1'b0;
    logic        violation = 1'b0;
    logic        sel = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    rtc_secs #(.FRAC_BITS(FRAC_BITS), .COMMIT_TICKS(COMMIT), .SYNC_STAGES(2)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_clk_i  (slow_clk),
        .violation_i (violation),
        .bus_sel_i   (sel),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Slow reference: toggles every two system clocks.
    always begin
        repeat (2) @(negedge clk);
        slow_clk = ~slow_clk;
    end

    function automatic logic [31:0] ctrl_view(input logic [31:0] d);
        return d & 32'h8;
    endfunction

    function automatic logic [31:0] ien_view(input logic [31:0] d);
        return d & 32'h0000_0390;
    endfunction

    function automatic longint tick_pos(input logic [31:0] s, input logic [31:0] f);
        return longint'(s) * FRAC_STEPS + longint'(f);
    endfunction

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=%0d cycles exp<%0d", cycles, WATCHDOG);
            report();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp = n_cmp + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    // Wait for write-complete, then clear it; report the clocks spent waiting.
    task automatic wait_done(input string req, output int waited);
        logic [31:0] s;
        waited = 0;
        rd(3'd5, s);
        while (!s[8] && waited < 200) begin
            @(negedge clk);
            waited = waited + 1;
            rd(3'd5, s);
        end
        if (!s[8]) chk(req, s & 32'h100, 32'h100);
        bus_wr(3'd5, 32'h100);
    endtask

    task automatic post(input logic [2:0] a, input logic [31:0] d);
        int w;
        bus_wr(a, d);
        wait_done("R3", w);
    endtask

    initial begin
        logic [31:0] v, s, f, old;
        longint t0, t1;
        int w;
        bit seen;
        void'($urandom(32'h5EC0_2D01));

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        rd(3'd0, v); chk("R1 seconds", v, 32'd0);
        rd(3'd1, v); chk("R1 fraction", v, 32'd0);
        rd(3'd2, v); chk("R1 alarm high", v, 32'hFFFF_FFFF);
        rd(3'd3, v); chk("R1 alarm low", v, 32'd0);
        rd(3'd4, v); chk("R1 control", v, 32'd0);
        rd(3'd5, v); chk("R1 status", v, 32'h0000_0202);
        rd(3'd6, v); chk("R1 int enable", v, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // R2: random posted writes read back after commit; R10 immediate enable
        for (int i = 0; i < 12; i++) begin
            logic [2:0] a;
            logic [31:0] d, exp;
            a = ($urandom % 3 == 0) ? 3'd4 : ((($urandom % 2) == 0) ? 3'd2 : 3'd3);
            d = $urandom;
            if (a == 3'd2 && d == 32'hFFFF_FFFF) d = 32'h1234;
            post(a, d);
            exp = (a == 3'd4) ? ctrl_view(d) : d;
            rd(a, v); chk("R2 readback", v, exp);
            d = $urandom;
            bus_wr(3'd6, d);
            rd(3'd6, v); chk("R2 int enable mask", v, ien_view(d));
            chk("R10 irq follows write-next enable", {31'd0, irq}, {31'd0, d[9]});
        end
        bus_wr(3'd6, 32'd0);
        post(3'd4, 32'd0);
        post(3'd2, 32'hFFFF_FFFF);
        bus_wr(3'd5, 32'h90);

        // R3: busy window, old value held, commit after COMMIT ticks
        rd(3'd3, old);
        bus_wr(3'd3, 32'hA5A5_0003);
        rd(3'd5, s);
        chk("R3 busy set", s & 32'h600, 32'h400);
        rd(3'd3, v); chk("R3 old value while busy", v, old);
        wait_done("R3", w);
        n_cmp = n_cmp + 1;
        if (w < (COMMIT - 1) * 4 || w > COMMIT * 4 + 4) begin
            n_bad = n_bad + 1;
            $display("FAIL R3 commit latency: act=%0d exp=%0d..%0d", w, (COMMIT - 1) * 4, COMMIT * 4 + 4);
        end
        rd(3'd3, v); chk("R3 committed value", v, 32'hA5A5_0003);
        rd(3'd5, s); chk("R3 next restored", s & 32'h700, 32'h200);

        // R4: second posted write during busy is dropped; R8 status write during busy
        bus_wr(3'd2, 32'h0000_0777);
        bus_wr(3'd2, 32'h0000_0888);
        bus_wr(3'd5, 32'h0);
        wait_done("R4", w);
        rd(3'd2, v); chk("R4 first write kept", v, 32'h0000_0777);
        rd(3'd5, s); chk("R4 error flag", s & 32'h80, 32'h80);
        bus_wr(3'd5, 32'h0);
        rd(3'd5, s); chk("R8 zero write keeps flags", s & 32'h82, 32'h82);
        bus_wr(3'd5, 32'h80);
        rd(3'd5, s); chk("R8 clear error", s & 32'h82, 32'h02);
        post(3'd2, 32'hFFFF_FFFF);

        // R5: enabled but never seeded stays frozen; R11 fraction-only load
        post(3'd4, 32'h8);
        repeat (100) @(negedge clk);
        rd(3'd0, v); chk("R5 unseeded seconds", v, 32'd0);
        rd(3'd1, v); chk("R5 unseeded fraction", v, 32'd0);
        post(3'd1, 32'h5);
        rd(3'd1, v); chk("R11 fraction load", v, 32'h5);
        rd(3'd0, v); chk("R11 seconds untouched", v, 32'd0);
        post(3'd0, 32'd100);
        rd(3'd0, s); rd(3'd1, f); t0 = tick_pos(s, f);
        repeat (160) @(negedge clk);
        rd(3'd0, s); rd(3'd1, f); t1 = tick_pos(s, f);
        n_cmp = n_cmp + 1;
        if (t1 - t0 < 39 || t1 - t0 > 41) begin
            n_bad = n_bad + 1;
            $display("FAIL R5 count rate: act=%0d exp=40+-1", t1 - t0);
        end
        post(3'd4, 32'h0);
        rd(3'd0, s); rd(3'd1, f); t0 = tick_pos(s, f);
        repeat (100) @(negedge clk);
        rd(3'd0, s); rd(3'd1, f); t1 = tick_pos(s, f);
        chk("R5 disabled holds", 32'(t1 - t0), 32'd0);

        // R6 seconds wrap with rollover; R7 all-ones alarm disabled
        post(3'd3, 32'd0);
        post(3'd1, 32'd13);
        post(3'd0, 32'hFFFF_FFFF);
        bus_wr(3'd5, 32'h10);
        post(3'd4, 32'h8);
        seen = 1'b0;
        for (int i = 0; i < 200 && !seen; i++) begin
            @(negedge clk);
            rd(3'd0, s);
            if (s != 32'hFFFF_FFFF) begin
                seen = 1'b1;
                rd(3'd1, f);
                chk("R6 seconds wrap", s, 32'd0);
                chk("R6 fraction zero at carry", f, 32'd0);
            end
        end
        chk("R6 carry observed", {31'd0, seen}, 32'd1);
        rd(3'd5, v); chk("R7 alarm disabled", v & 32'h10, 32'd0);

        // R7 alarm match and R10 interrupt
        post(3'd4, 32'h0);
        post(3'd1, 32'd0);
        post(3'd0, 32'd50);
        post(3'd2, 32'd51);
        post(3'd3, 32'hF0F0_0003);
        bus_wr(3'd6, 32'h10);
        post(3'd4, 32'h8);
        seen = 1'b0;
        for (int i = 0; i < 400 && !seen; i++) begin
            @(negedge clk);
            rd(3'd5, v);
            if (v[4]) begin
                seen = 1'b1;
                rd(3'd0, s); rd(3'd1, f);
                chk("R7 alarm seconds", s, 32'd51);
                chk("R7 alarm fraction", f, 32'd3);
                chk("R10 alarm irq", {31'd0, irq}, 32'd1);
            end
        end
        chk("R7 alarm seen", {31'd0, seen}, 32'd1);
        bus_wr(3'd5, 32'h10);
        rd(3'd5, v); chk("R8 clear alarm", v & 32'h10, 32'd0);
        chk("R10 irq drops", {31'd0, irq}, 32'd0);
        repeat (200) @(negedge clk);
        rd(3'd5, v); chk("R7 fires once", v & 32'h10, 32'd0);

        // R9 validity and security flags
        @(negedge clk); violation = 1'b1;
        @(negedge clk); violation = 1'b0;
        rd(3'd5, v); chk("R9 violation sets", v & 32'h3, 32'h3);
        bus_wr(3'd5, 32'h2);
        rd(3'd5, v); chk("R9 single bit no clear", v & 32'h3, 32'h3);
        bus_wr(3'd5, 32'h1);
        rd(3'd5, v); chk("R9 other bit no clear", v & 32'h3, 32'h3);
        bus_wr(3'd5, 32'h3);
        rd(3'd5, v); chk("R9 pair clear", v & 32'h3, 32'h0);

        // R10 error gating
        bus_wr(3'd6, 32'h80);
        bus_wr(3'd3, 32'h1);
        bus_wr(3'd3, 32'h2);
        chk("R10 error irq", {31'd0, irq}, 32'd1);
        wait_done("R10", w);
        bus_wr(3'd6, 32'h0);
        chk("R10 masked", {31'd0, irq}, 32'd0);
        bus_wr(3'd5, 32'h80);

        report();
    end

endmodule